// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a small processor core, together with one saved-status word for each exception mode. Software sees sixteen logical registers. The physical storage behind some of them depends on the processor mode presented on `mode_i`. In user mode a program sees only the shared set.

Each exception mode (fast interrupt, normal interrupt, supervisor, abort, undefined) has its own stack pointer (register 13), its own link register (register 14) and its own saved-status word. The fast-interrupt mode also has private copies of registers 8 through 12. Registers 0 to 7 and register 15 are the same storage in every mode.

The core reads two operands and writes one result per cycle, using logical register numbers. A separate exception-entry port stores a return address and a status word in one cycle. It targets the bank of the mode being entered, so it works while `mode_i` still shows the interrupted mode. Every pin is a plain control or data pin with no handshake. A read is combinational and a write takes effect at the rising clock edge.

Top module: `bankrf_top`

## Requirements
- R1: After an active-low reset, every logical register reads zero in every mode, and the saved-status output reads zero.
- R2: Registers 0 to 7 and register 15 are one shared copy. A value written in any mode reads back in every mode code 0 to 7.
- R3: Registers 8 to 12 have one copy for the fast-interrupt mode (code 1). Every other mode code shares a second copy.
- R4: Registers 13 and 14 have a private copy for each exception mode. The mode codes are: 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. User mode (code 0) and the unassigned codes 6 and 7 share one copy.
- R5: Read ports A and B are combinational. When the write port targets the physical register a read port addresses in the same cycle, that read port returns the incoming write data.
- R6: When `wr_en` is high, `wr_data` is stored at the rising edge in the register that `wr_idx` selects in the bank of `mode_i`.
- R7: Each exception mode has its own saved-status word, written through `sts_wr_en`/`sts_wr_data` and read on `sts_rd_data`. A pending write is forwarded to `sts_rd_data`. For codes 0, 6 and 7, `sts_rd_data` is zero and `sts_wr_en` has no effect.
- R8: When `exc_en` is high and `exc_mode` is an exception mode, the rising edge stores `exc_link` in register 14 and `exc_status` in the saved-status word of `exc_mode`'s bank, whatever `mode_i` shows. If this collides with a same-cycle write from the normal ports, the exception-entry value wins, both in storage and on the forwarded read.
- R9: An exception-entry write whose `exc_mode` is 0, 6 or 7 changes no register and no saved-status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Current processor mode code |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write strobe for the general write port |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Data to write |
| sts_wr_en | input | 1 | Write strobe for the current mode's saved-status word |
| sts_wr_data | input | DATA_W | Saved-status write data |
| sts_rd_data | output | DATA_W | Saved-status word of the current mode |
| exc_en | input | 1 | Exception-entry write strobe |
| exc_mode | input | 3 | Mode being entered |
| exc_link | input | DATA_W | Return address for the new mode's register 14 |
| exc_status | input | DATA_W | Status word for the new mode's saved-status register |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume that `mode_i`, the indices and the strobes stay constant between one falling edge and the next rising edge. The bench meets both assumptions: it holds all inputs at zero through reset and changes them only at falling edges. The commit properties take for granted that a write and an exception entry to the same target resolve by the stated priority. The bench drives exactly that collision once, to check that the exception value wins. The sweep covers all eight mode codes, including the unassigned ones, so the codes that fall back to the user bank are exercised as well.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int MODE_W   = 3;
  localparam int LOG_REGS = 16;
  localparam int LIDX_W   = $clog2(LOG_REGS);
  localparam int NUM_EXC  = 5;
  localparam int SLOT_W   = $clog2(NUM_EXC);
  localparam int FAST_LO  = 8;
  localparam int FAST_HI  = 12;
  localparam int FAST_CNT = FAST_HI - FAST_LO + 1;
  localparam int SP_IDX   = 13;
  localparam int LR_IDX   = 14;

  // physical layout: logical 0..15 (user/shared), fast copies, per-mode SP, per-mode LR
  localparam int FAST_BASE = LOG_REGS;
  localparam int SP_BASE   = FAST_BASE + FAST_CNT;
  localparam int LR_BASE   = SP_BASE + NUM_EXC;
  localparam int PHYS_REGS = LR_BASE + NUM_EXC;
  localparam int PHYS_W    = $clog2(PHYS_REGS);

  typedef enum logic [MODE_W-1:0] {
    MD_USER = 3'd0,
    MD_FAST = 3'd1,
    MD_IRQ  = 3'd2,
    MD_SVC  = 3'd3,
    MD_ABT  = 3'd4,
    MD_UND  = 3'd5,
    MD_RSV6 = 3'd6,
    MD_RSV7 = 3'd7
  } mode_e;

  function automatic logic is_exc(input logic [MODE_W-1:0] m);
    return (int'(m) >= int'(MD_FAST)) && (int'(m) <= int'(MD_UND));
  endfunction

  function automatic logic [SLOT_W-1:0] exc_slot(input logic [MODE_W-1:0] m);
    return SLOT_W'(int'(m) - int'(MD_FAST));
  endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [LIDX_W-1:0] lidx,
  output logic [PHYS_W-1:0] pidx
);

  logic exc_m;
  logic fast_m;
  logic in_fast_range;
  int   slot;
  int   li;

  always_comb begin
    li            = int'(lidx);
    exc_m         = is_exc(mode);
    fast_m        = (mode == MD_FAST);
    in_fast_range = (li >= FAST_LO) && (li <= FAST_HI);
    slot          = int'(exc_slot(mode));
    pidx          = PHYS_W'(li);
    if (fast_m && in_fast_range) begin
      pidx = PHYS_W'(FAST_BASE + li - FAST_LO);
    end else if (exc_m && li == SP_IDX) begin
      pidx = PHYS_W'(SP_BASE + slot);
    end else if (exc_m && li == LR_IDX) begin
      pidx = PHYS_W'(LR_BASE + slot);
    end
  end

endmodule

// File: rtl/bankrf_gpr.sv
module bankrf_gpr
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NRD    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         w0_en,
  input  logic [PHYS_W-1:0]            w0_pidx,
  input  logic [DATA_W-1:0]            w0_data,
  input  logic                         w1_en,
  input  logic [PHYS_W-1:0]            w1_pidx,
  input  logic [DATA_W-1:0]            w1_data,
  input  logic [NRD-1:0][PHYS_W-1:0]   rd_pidx,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);

  logic [DATA_W-1:0] mem [PHYS_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PHYS_REGS; k++) mem[k] <= '0;
    end else begin
      if (w0_en) mem[w0_pidx] <= w0_data;
      if (w1_en) mem[w1_pidx] <= w1_data;  // later assignment: entry port wins
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic hit0;
    logic hit1;
    always_comb begin
      hit0 = w0_en && (w0_pidx == rd_pidx[p]);
      hit1 = w1_en && (w1_pidx == rd_pidx[p]);
      if (hit1)      rd_data[p] = w1_data;
      else if (hit0) rd_data[p] = w0_data;
      else           rd_data[p] = mem[rd_pidx[p]];
    end
  end

  // R6: a general write is visible in storage after the edge
  p_wr_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w0_en && !(w1_en && w1_pidx == w0_pidx)) |=> mem[$past(w0_pidx)] == $past(w0_data));

  // R8: an exception-entry write is visible in storage after the edge
  p_exc_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w1_en |=> mem[$past(w1_pidx)] == $past(w1_data));

endmodule

// File: rtl/bankrf_sts.sv
module bankrf_sts
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                exc_en,
  input  logic [MODE_W-1:0]   exc_mode,
  input  logic [DATA_W-1:0]   exc_data,
  output logic [DATA_W-1:0]   rd_data
);

  logic [NUM_EXC-1:0][DATA_W-1:0] saved;
  logic              cur_ok;
  logic              exc_ok;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] exc_sl;
  logic              wr_go;
  logic              exc_go;

  always_comb begin
    cur_ok   = is_exc(cur_mode);
    exc_ok   = is_exc(exc_mode);
    cur_slot = exc_slot(cur_mode);
    exc_sl   = exc_slot(exc_mode);
    wr_go    = wr_en && cur_ok;
    exc_go   = exc_en && exc_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved <= '0;
    end else begin
      if (wr_go)  saved[cur_slot] <= wr_data;
      if (exc_go) saved[exc_sl]   <= exc_data;
    end
  end

  always_comb begin
    if (!cur_ok)                        rd_data = '0;
    else if (exc_go && exc_sl == cur_slot) rd_data = exc_data;
    else if (wr_go)                     rd_data = wr_data;
    else                                rd_data = saved[cur_slot];
  end

  // R7: a status write in an exception mode lands in that mode's slot
  p_sts_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !(exc_go && exc_sl == cur_slot)) |=> saved[$past(cur_slot)] == $past(wr_data));

  // R9: entry into a non-exception mode leaves every saved word alone
  p_exc_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && !exc_ok && !wr_go) |=> $stable(saved));

endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [LIDX_W-1:0]   rd_a_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [LIDX_W-1:0]   rd_b_idx,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                wr_en,
  input  logic [LIDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                sts_wr_en,
  input  logic [DATA_W-1:0]   sts_wr_data,
  output logic [DATA_W-1:0]   sts_rd_data,
  input  logic                exc_en,
  input  logic [MODE_W-1:0]   exc_mode,
  input  logic [DATA_W-1:0]   exc_link,
  input  logic [DATA_W-1:0]   exc_status
);

  localparam int NRD  = 2;
  localparam int NMAP = NRD + 2;  // read ports, general write, entry write

  logic [NMAP-1:0][MODE_W-1:0] map_mode;
  logic [NMAP-1:0][LIDX_W-1:0] map_lidx;
  logic [NMAP-1:0][PHYS_W-1:0] map_pidx;
  logic [NRD-1:0][PHYS_W-1:0]  rd_pidx;
  logic [NRD-1:0][DATA_W-1:0]  rd_data;
  logic                        exc_go;

  always_comb begin
    map_mode[0] = mode_i;   map_lidx[0] = rd_a_idx;
    map_mode[1] = mode_i;   map_lidx[1] = rd_b_idx;
    map_mode[2] = mode_i;   map_lidx[2] = wr_idx;
    map_mode[3] = exc_mode; map_lidx[3] = LIDX_W'(LR_IDX);
    rd_pidx[0]  = map_pidx[0];
    rd_pidx[1]  = map_pidx[1];
    exc_go      = exc_en && is_exc(exc_mode);
  end

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    bankrf_map u_map (
      .mode (map_mode[m]),
      .lidx (map_lidx[m]),
      .pidx (map_pidx[m])
    );
  end

  bankrf_gpr #(.DATA_W(DATA_W), .NRD(NRD)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .w0_en   (wr_en),
    .w0_pidx (map_pidx[2]),
    .w0_data (wr_data),
    .w1_en   (exc_go),
    .w1_pidx (map_pidx[3]),
    .w1_data (exc_link),
    .rd_pidx (rd_pidx),
    .rd_data (rd_data)
  );

  bankrf_sts #(.DATA_W(DATA_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (mode_i),
    .wr_en    (sts_wr_en),
    .wr_data  (sts_wr_data),
    .exc_en   (exc_en),
    .exc_mode (exc_mode),
    .exc_data (exc_status),
    .rd_data  (sts_rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  // R5: same-mode write to the index read on port A is forwarded
  p_fwd_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx && !exc_en) |-> rd_a_data == wr_data);

  // R7: no saved-status value is visible outside the exception modes
  p_user_sts_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_exc(mode_i) |-> sts_rd_data == '0);

  // R2: shared low registers read the same on both ports regardless of mode
  p_shared_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);

endmodule

// File: tb/bankrf_top_tb.sv
module bankrf_top_tb;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode_i = '0;
  logic [3:0]    rd_a_idx = '0;
  logic [DW-1:0] rd_a_data;
  logic [3:0]    rd_b_idx = '0;
  logic [DW-1:0] rd_b_data;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic          sts_wr_en = 1'b0;
  logic [DW-1:0] sts_wr_data = '0;
  logic [DW-1:0] sts_rd_data;
  logic          exc_en = 1'b0;
  logic [2:0]    exc_mode = '0;
  logic [DW-1:0] exc_link = '0;
  logic [DW-1:0] exc_status = '0;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  bankrf_top #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_link(exc_link), .exc_status(exc_status)
  );

  function automatic int norm(input int m);
    return (m >= 1 && m <= 5) ? m : 0;
  endfunction

  function automatic bit shares(input int m1, input int m2, input int i);
    if (i < 8 || i == 15) return 1'b1;
    if (i <= 12) return (norm(m1) == 1) == (norm(m2) == 1);
    return norm(m1) == norm(m2);
  endfunction

  function automatic logic [DW-1:0] val(input int m, input int i);
    return 32'hC0DE_0000 | (m << 8) | i;
  endfunction

  function automatic logic [DW-1:0] sweep_exp(input int m, input int i);
    for (int w = 5; w >= 0; w--) if (shares(m, w, i)) return val(w, i);
    return '0;
  endfunction

  function automatic string tag_of(input int i);
    if (i < 8 || i == 15) return "R2";
    if (i <= 12) return "R3";
    return "R4";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(input int m, input int i, input logic [DW-1:0] d);
    @(negedge clk);
    mode_i = 3'(m); wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_sts_write(input int m, input logic [DW-1:0] d);
    @(negedge clk);
    mode_i = 3'(m); sts_wr_en = 1'b1; sts_wr_data = d;
    @(negedge clk);
    sts_wr_en = 1'b0;
  endtask

  task automatic do_exc(input int cur, input int m, input logic [DW-1:0] l,
                        input logic [DW-1:0] s);
    @(negedge clk);
    mode_i = 3'(cur); exc_en = 1'b1; exc_mode = 3'(m); exc_link = l; exc_status = s;
    @(negedge clk);
    exc_en = 1'b0;
  endtask

  task automatic setread(input int m, input int a, input int b);
    @(negedge clk);
    mode_i = 3'(m); rd_a_idx = 4'(a); rd_b_idx = 4'(b);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      setread(0, i, 15 - i);
      check("R1", "reset port A", rd_a_data, '0);
      check("R1", "reset port B", rd_b_data, '0);
    end
    for (int m = 0; m < 8; m++) begin
      setread(m, 13, 14);
      check("R1", "reset banked", rd_a_data | rd_b_data, '0);
      check("R1", "reset status", sts_rd_data, '0);
    end

    // R6: write every register in modes 0..5
    for (int m = 0; m < 6; m++)
      for (int i = 0; i < 16; i++) do_write(m, i, val(m, i));

    // R2 R3 R4: read back in all eight mode codes
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i++) begin
        setread(m, i, (i + 5) % 16);
        check(tag_of(i), "sweep port A", rd_a_data, sweep_exp(m, i));
        check(tag_of((i + 5) % 16), "sweep port B", rd_b_data, sweep_exp(m, (i + 5) % 16));
      end

    // R5: forwarding of a pending write
    @(negedge clk);
    mode_i = 3'd1; rd_a_idx = 4'd10; rd_b_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'hF00D_000A;
    #1;
    check("R5", "forwarded port A", rd_a_data, 32'hF00D_000A);
    check("R5", "unrelated port B", rd_b_data, sweep_exp(1, 3));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R6", "committed fast r10", rd_a_data, 32'hF00D_000A);
    setread(2, 10, 10);
    check("R3", "user copy r10 untouched", rd_a_data, sweep_exp(2, 10));

    // R7: saved-status words
    for (int m = 1; m < 6; m++) do_sts_write(m, 32'h5A00_0000 | m);
    do_sts_write(0, 32'hDEAD_0000);
    do_sts_write(6, 32'hDEAD_0006);
    for (int m = 0; m < 8; m++) begin
      setread(m, 0, 0);
      check("R7", "status readback", sts_rd_data,
            (norm(m) == 0) ? 32'h0 : (32'h5A00_0000 | m));
    end
    @(negedge clk);
    mode_i = 3'd4; sts_wr_en = 1'b1; sts_wr_data = 32'h7777_0004;
    #1;
    check("R7", "status forward", sts_rd_data, 32'h7777_0004);
    @(negedge clk);
    sts_wr_en = 1'b0;
    #1;
    check("R7", "status committed", sts_rd_data, 32'h7777_0004);

    // R8: entry write from user mode into the interrupt bank
    do_exc(0, 2, 32'h1111_0002, 32'h2222_0002);
    setread(2, 14, 13);
    check("R8", "irq link", rd_a_data, 32'h1111_0002);
    check("R8", "irq sp untouched", rd_b_data, sweep_exp(2, 13));
    check("R8", "irq status", sts_rd_data, 32'h2222_0002);
    setread(0, 14, 14);
    check("R8", "user link untouched", rd_a_data, sweep_exp(0, 14));

    // R8: collision with the general port, entry wins
    @(negedge clk);
    mode_i = 3'd3; rd_a_idx = 4'd14; rd_b_idx = 4'd14;
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'h9999_9999;
    exc_en = 1'b1; exc_mode = 3'd3; exc_link = 32'h3333_0003; exc_status = 32'h4444_0003;
    #1;
    check("R8", "collision forward", rd_a_data, 32'h3333_0003);
    check("R8", "status entry forward", sts_rd_data, 32'h4444_0003);
    @(negedge clk);
    wr_en = 1'b0; exc_en = 1'b0;
    #1;
    check("R8", "collision committed", rd_b_data, 32'h3333_0003);

    // R9: entry into non-exception codes is ignored
    do_exc(1, 0, 32'hBAD0_BAD0, 32'hBAD1_BAD1);
    do_exc(2, 7, 32'hBAD2_BAD2, 32'hBAD3_BAD3);
    setread(0, 14, 13);
    check("R9", "user link kept", rd_a_data, sweep_exp(0, 14));
    check("R9", "user sp kept", rd_b_data, sweep_exp(0, 13));
    setread(6, 14, 14);
    check("R9", "code 6 link kept", rd_a_data, sweep_exp(0, 14));
    for (int m = 1; m < 6; m++) begin
      setread(m, 14, 14);
      check("R9", "status kept", sts_rd_data,
            (m == 2) ? 32'h2222_0002 : (m == 3) ? 32'h4444_0003 :
            (m == 4) ? 32'h7777_0004 : (32'h5A00_0000 | m));
      check("R9", "link kept", rd_a_data,
            (m == 2) ? 32'h1111_0002 : (m == 3) ? 32'h3333_0003 : sweep_exp(m, 14));
    end

    finish_run();
  end

endmodule